// File: doc/BRIEF.md
# Offset-Coefficient FIR Filter Engine

This block is a sequential finite impulse response filter. It takes unsigned 8-bit samples and signed 8-bit taps. It never multiplies signed numbers. Each tap is kept as an unsigned value, the tap plus 128. The bias that this adds to the result is removed with 128 times a running total of the stored samples. The running total is held as 256 times the sample sum and is halved when it is used.

A new sample goes into a circular history and replaces the oldest entry. The running total is updated at the same time: the outgoing sample is subtracted and the incoming one is added. The engine then takes `TAPS` products, pairing tap k with the sample k positions older than the newest. It does `LANES` products per clock, so one result takes ceil(TAPS/LANES) clocks.

The sample input uses a valid/ready handshake. `smp_ready` is low while a result is being computed. A sample offered in that time is dropped and raises a sticky overrun flag; the source is expected to honour `smp_ready`. The result port has no back-pressure: `res_valid` is a one-cycle strobe, and `res_data` holds its value until the next strobe. Tap writes take effect in the cycle after the write.

Top module: `offset_fir`

## Requirements
- R1: While `tap_we` is high, the signed value `tap_val` becomes tap number `tap_idx`, and tap 0 pairs with the newest sample. After reset every tap is zero, so the first result is 0 for any sample.
- R2: A sample is accepted at a rising edge where both `smp_valid` and `smp_ready` are high. `smp_ready` is low from the cycle after acceptance up to the cycle in which `res_valid` is high.
- R3: Each result is the sum of tap[k] times the sample k places older than the newest, over k = 0 to TAPS-1. The newest sample is the one just accepted.
- R4: `res_valid` is high for exactly one cycle, ceil(TAPS/LANES) rising edges after the edge that accepted the sample.
- R5: After reset `res_valid` is 0, `overrun` is 0, `smp_ready` is 1, and the sample history and running sum are zero.
- R6: The history is circular: once more than TAPS samples have been accepted, the oldest one no longer affects the result.
- R7: When TAPS is not a multiple of LANES, the unused lanes in the final step add zero.
- R8: A sample offered while `smp_ready` is low is ignored, and `overrun` goes to 1. It stays at 1 until reset.
- R9: `res_data` is a 24-bit two's-complement value. With all taps at -128 or all at +127, and every sample at 255, the exact signed result is given.
- R10: The accumulator starts from zero for every result, so no partial sum carries over from the previous output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Engine idle, sample can be taken |
| smp_data | input | 8 | Unsigned sample |
| tap_we | input | 1 | Tap write strobe |
| tap_idx | input | $clog2(TAPS) | Tap number to write |
| tap_val | input | 8 | Signed tap value |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 24 | Signed filter output |
| overrun | output | 1 | Sticky flag: a sample was offered while busy |

## Verification
The taps hold mixed signs, including both extremes, and a sample sequence longer than the history is applied. This separates correct tap-to-age pairing and circular wrap from a reversed order or a stale oldest entry. A sample applied while all taps are still at their reset value must give zero. A uniform run of samples at full scale, with all taps at +127 and then all at -128, exercises the bias removal at both ends of the range. It also shows whether the halving of the running sum is wrong. With three lanes and eight taps, a sample offered during a computation shows whether dropped samples leak into the history. The same setup shows whether the ninth, unused lane adds a product.

// File: rtl/ofir_pkg.sv
package ofir_pkg;
  localparam int SAMPLE_W = 8;
  localparam int TAP_W    = 8;
  localparam int OUT_W    = 24;
  localparam int SUM_W    = 24;
  localparam int ACC_W    = 32;

  typedef logic [SAMPLE_W-1:0] sample_t;
  typedef logic [TAP_W-1:0]    utap_t;
  typedef logic [ACC_W-1:0]    acc_t;
  typedef logic [SUM_W-1:0]    sum_t;

  // signed tap plus 128 equals the tap with its sign bit inverted
  function automatic utap_t biased(input logic [TAP_W-1:0] t);
    return {~t[TAP_W-1], t[TAP_W-2:0]};
  endfunction
endpackage

// File: rtl/ofir_history.sv
module ofir_history
  import ofir_pkg::*;
#(
  parameter int TAPS = 8,
  localparam int IDX_W = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  sample_t          din,
  output sample_t          hist_o [TAPS],
  output logic [IDX_W-1:0] newest_o,
  output sum_t             sum256_o
);
  sample_t          hist [TAPS];
  logic [IDX_W-1:0] wr_ptr;
  logic [IDX_W-1:0] newest;
  sum_t             sum256;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) hist[i] <= '0;
      wr_ptr <= '0;
      newest <= IDX_W'(TAPS - 1);
      sum256 <= '0;
    end else if (push) begin
      // drop the slot being overwritten and add the incoming sample, both times 256
      sum256 <= sum256 - {8'(hist[wr_ptr]), 8'h00} + {8'(din), 8'h00};
      hist[wr_ptr] <= din;
      newest <= wr_ptr;
      wr_ptr <= (wr_ptr == IDX_W'(TAPS - 1)) ? '0 : wr_ptr + 1'b1;
    end
  end

  assign hist_o   = hist;
  assign newest_o = newest;
  assign sum256_o = sum256;
endmodule

// File: rtl/ofir_tap_store.sv
module ofir_tap_store
  import ofir_pkg::*;
#(
  parameter int TAPS = 8,
  localparam int IDX_W = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAP_W-1:0] val,
  output utap_t            tap_o [TAPS]
);
  utap_t taps [TAPS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) taps[i] <= biased('0);
    end else if (we) begin
      taps[idx] <= biased(val);
    end
  end

  assign tap_o = taps;
endmodule

// File: rtl/ofir_mac_lanes.sv
module ofir_mac_lanes
  import ofir_pkg::*;
#(
  parameter int TAPS  = 8,
  parameter int LANES = 3,
  localparam int IDX_W  = $clog2(TAPS),
  localparam int STEPS  = (TAPS + LANES - 1) / LANES,
  localparam int STEP_W = $clog2(STEPS + 1)
) (
  input  sample_t           hist [TAPS],
  input  utap_t             taps [TAPS],
  input  logic [IDX_W-1:0]  newest,
  input  logic [STEP_W-1:0] step,
  output acc_t              lane_sum
);
  acc_t prod [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    int age;
    int slot;
    always_comb begin
      age  = int'(step) * LANES + g;
      slot = int'(newest) - age;
      if (slot < 0) slot = slot + TAPS;
      if (age < TAPS)
        prod[g] = ACC_W'(hist[slot[IDX_W-1:0]]) * ACC_W'(taps[age[IDX_W-1:0]]);
      else
        prod[g] = '0;
    end
  end

  always_comb begin
    lane_sum = '0;
    for (int g = 0; g < LANES; g++) lane_sum = lane_sum + prod[g];
  end
endmodule

// File: rtl/offset_fir.sv
module offset_fir
  import ofir_pkg::*;
#(
  parameter int TAPS  = 8,
  parameter int LANES = 3,
  localparam int IDX_W  = $clog2(TAPS),
  localparam int STEPS  = (TAPS + LANES - 1) / LANES,
  localparam int STEP_W = $clog2(STEPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic [7:0]       smp_data,
  input  logic             tap_we,
  input  logic [IDX_W-1:0] tap_idx,
  input  logic [7:0]       tap_val,
  output logic             res_valid,
  output logic [23:0]      res_data,
  output logic             overrun
);
  sample_t           hist [TAPS];
  utap_t             taps [TAPS];
  logic [IDX_W-1:0]  newest;
  sum_t              sum256;
  acc_t              lane_sum;
  acc_t              acc;
  logic              busy;
  logic [STEP_W-1:0] step;
  logic              take;

  assign smp_ready = !busy;
  assign take      = smp_valid && !busy;

  ofir_history #(.TAPS(TAPS)) u_hist (
    .clk(clk), .rst_n(rst_n), .push(take), .din(smp_data),
    .hist_o(hist), .newest_o(newest), .sum256_o(sum256)
  );

  ofir_tap_store #(.TAPS(TAPS)) u_taps (
    .clk(clk), .rst_n(rst_n), .we(tap_we), .idx(tap_idx), .val(tap_val),
    .tap_o(taps)
  );

  ofir_mac_lanes #(.TAPS(TAPS), .LANES(LANES)) u_mac (
    .hist(hist), .taps(taps), .newest(newest), .step(step),
    .lane_sum(lane_sum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      step      <= '0;
      acc       <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      overrun   <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (take) begin
        busy <= 1'b1;
        step <= '0;
        acc  <= '0;
      end else if (busy) begin
        if (step == STEP_W'(STEPS - 1)) begin
          // bias removal: subtract half of the x256 running sum
          res_data  <= OUT_W'(acc + lane_sum - ACC_W'(sum256 >> 1));
          res_valid <= 1'b1;
          busy      <= 1'b0;
        end else begin
          acc  <= acc + lane_sum;
          step <= step + 1'b1;
        end
      end
      if (smp_valid && busy) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/offset_fir_checker.sv
module offset_fir_checker (
  input logic clk,
  input logic rst_n,
  input logic smp_valid,
  input logic smp_ready,
  input logic res_valid,
  input logic overrun
);
  // R4
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  // R2
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> !smp_ready);
  // R2
  ready_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> smp_ready);
  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready) |=> overrun);
  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

bind offset_fir offset_fir_checker u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .res_valid(res_valid), .overrun(overrun)
);

// File: tb/offset_fir_test.sv
module offset_fir_test;
  localparam int TAPS  = 8;
  localparam int LANES = 3;
  localparam int LAT   = (TAPS + LANES - 1) / LANES;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [7:0]  smp_data = '0;
  logic        tap_we = 1'b0;
  logic [2:0]  tap_idx = '0;
  logic [7:0]  tap_val = '0;
  logic        res_valid;
  logic [23:0] res_data;
  logic        overrun;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int mtap [TAPS];
  int mhist [TAPS];

  localparam int TAPSET [TAPS] = '{-128, 127, 5, -3, 64, -1, 0, 33};
  localparam logic [7:0] STIM [12] = '{8'd255, 8'd0, 8'd17, 8'd128, 8'd1, 8'd200,
                                       8'd99, 8'd255, 8'd3, 8'd64, 8'd250, 8'd12};

  always #10 clk = ~clk;

  offset_fir #(.TAPS(TAPS), .LANES(LANES)) uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .tap_we(tap_we), .tap_idx(tap_idx), .tap_val(tap_val),
    .res_valid(res_valid), .res_data(res_data), .overrun(overrun)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_out();
    int s = 0;
    for (int k = 0; k < TAPS; k++) s += mtap[k] * mhist[k];
    return s;
  endfunction

  task automatic model_push(input int x);
    for (int k = TAPS - 1; k > 0; k--) mhist[k] = mhist[k-1];
    mhist[0] = x;
  endtask

  task automatic write_tap(input int i, input int v);
    @(negedge clk);
    tap_we = 1'b1; tap_idx = 3'(i); tap_val = 8'(v);
    @(negedge clk);
    tap_we = 1'b0;
    mtap[i] = v;
  endtask

  // waits for the strobe, checks its delay, value and one-cycle width
  task automatic collect(input int lat_exp, input string req);
    int n = 0;
    int exp = model_out();
    while (!res_valid && n < 20) begin
      @(negedge clk);
      n++;
    end
    check(n == lat_exp, "R4 latency", n, lat_exp);
    check($signed(res_data) == exp, req, $signed(res_data), exp);
    @(negedge clk);
    check(!res_valid, "R4 single-cycle strobe", int'(res_valid), 0);
  endtask

  task automatic send(input int x, input string req);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = 8'(x);
    @(negedge clk);
    smp_valid = 1'b0;
    check(!smp_ready, "R2 ready low while busy", int'(smp_ready), 0);
    model_push(x);
    collect(LAT, req);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < TAPS; k++) begin mtap[k] = 0; mhist[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R5
    check(!res_valid, "R5 res_valid after reset", int'(res_valid), 0);
    check(smp_ready, "R5 ready after reset", int'(smp_ready), 1);
    check(!overrun, "R5 overrun after reset", int'(overrun), 0);
    // R1: taps are zero after reset
    send(200, "R1 reset taps give zero");

    for (int k = 0; k < TAPS; k++) write_tap(k, TAPSET[k]);
    // R3 R6 R7 R10: table walk, longer than the history
    foreach (STIM[i]) send(int'(STIM[i]), "R3 R6 R7 R10 table result");

    // R9: extremes
    for (int k = 0; k < TAPS; k++) write_tap(k, 127);
    for (int i = 0; i < TAPS; i++) send(255, "R9 positive extreme");
    check($signed(res_data) == 259080, "R9 max value", $signed(res_data), 259080);
    for (int k = 0; k < TAPS; k++) write_tap(k, -128);
    send(255, "R9 negative extreme");
    check($signed(res_data) == -261120, "R9 min value", $signed(res_data), -261120);

    // R1: newest pairs with tap 0 only
    for (int k = 0; k < TAPS; k++) write_tap(k, 0);
    write_tap(0, -7);
    send(9, "R1 tap0 pairs newest");
    check($signed(res_data) == -63, "R1 single tap", $signed(res_data), -63);

    // R8: sample while busy is ignored
    for (int k = 0; k < TAPS; k++) write_tap(k, TAPSET[k]);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = 8'd10;
    @(negedge clk);
    smp_data = 8'd99;
    check(!smp_ready, "R2 not ready during compute", int'(smp_ready), 0);
    @(negedge clk);
    smp_valid = 1'b0;
    check(overrun, "R8 overrun set", int'(overrun), 1);
    model_push(10);
    collect(LAT - 1, "R8 result unaffected");
    send(7, "R8 dropped sample absent from history");
    check(overrun, "R8 overrun sticky", int'(overrun), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule